// File: doc/BRIEF.md
# Synchronized serial strobe generator

This block derives a serial clock, a data line pattern and an active-low chip select from a single fast system clock. All three lines come from one clocked control path that shares one tick divider. Their transitions are therefore locked to the same base tick and cannot drift apart. With the default settings, a 40 MHz system clock gives a 1 MHz serial clock, because the serial clock level flips every 20 system cycles.

A one-cycle start pulse in idle begins a frame. The serial clock then runs for a set number of complete cycles with chip select high. Chip select then goes low for a further set number of cycles, and the serial clock keeps running through that change with no gap. The data line starts high and flips after every group of a set number of serial clock cycles. When the frame ends, every line returns to its idle level and the busy flag drops.

There is no data stream at the edge of this block. Start and busy are plain control and status pins, and no back-pressure applies.

Top module: `serial_strobe_gen`

## Requirements
- R1: After a synchronous reset, the outputs are sclk=0, sdata=0, cs_n=1 and busy=0 from the next clock edge on.
- R2: The serial clock stays low for the HALF_TICKS (default 20) system cycles that start at the accept edge. After that it alternates, flipping every HALF_TICKS edges. At edge n after the accept edge (n=0 is the accept edge), sclk equals floor(n/HALF_TICKS) mod 2.
- R3: While busy is low, sclk and sdata are held at 0 and cs_n is held at 1.
- R4: cs_n falls on the same edge where sclk falls to complete serial cycle number PRE_CYCLES (default 8), which is PRE_CYCLES*2*HALF_TICKS edges after the accept edge. cs_n stays low for SEL_CYCLES (default 4) complete serial cycles.
- R5: sdata is 1 during the first DATA_CYCLES (default 2) serial cycles of a frame and flips at the end of every later group of DATA_CYCLES cycles. For serial cycle index k, sdata = 1 when floor(k/DATA_CYCLES) is even.
- R6: Through the whole frame, including the chip select transition, sclk flips every HALF_TICKS edges with no gap. The frame ends (PRE_CYCLES+SEL_CYCLES)*2*HALF_TICKS edges after the accept edge, and at that edge busy falls.
- R7: A start pulse while busy is high is ignored. This includes a pulse in the last cycle of a frame. Such a pulse neither restarts nor lengthens the frame.
- R8: A synchronous reset in the middle of a frame aborts it and clears every counter. The next frame again begins with a full low half period.
- R9: A start pulse sampled while idle is accepted on that edge. busy rises at that edge, with sclk=0, sdata=1 and cs_n=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin a frame |
| sclk | output | 1 | Serial clock, registered |
| sdata | output | 1 | Data line pattern, registered |
| cs_n | output | 1 | Chip select, active low, registered |
| busy | output | 1 | High while a frame runs |

## Verification
On every cycle the assertions check the following. The idle levels match busy. Chip select only falls together with a falling serial clock. The tick counter stays in range. The serial clock never holds a level longer than a half period while busy. A select phase never jumps straight back to clocking. The exact cycle on which each line moves, the data grouping, the handling of start pulses while busy (including the final cycle) and the clean restart after a mid-frame reset are shown only by the bench scenarios. These compare every output on every cycle of a frame against a model built from the requirements.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CLOCKING = 2'd1,
    ST_SELECT   = 2'd2
  } ssg_state_e;

endpackage

// File: rtl/ssg_tick_div.sv
module ssg_tick_div #(
  parameter int HALF_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic half_tick
);

  localparam int TW = $clog2(HALF_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);

  logic [TW-1:0] cnt_q;

  assign half_tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST) else $error("tick counter out of range"); // R2

  AST_TICK_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0) else $error("tick counter moved while idle"); // R8

endmodule

// File: rtl/ssg_ctrl.sv
module ssg_ctrl
  import ssg_pkg::*;
#(
  parameter int PRE_CYCLES = 8,
  parameter int SEL_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       half_tick,
  input  logic       sclk_q,
  output ssg_state_e state_q,
  output logic       accept,
  output logic       cyc_end,
  output logic       enter_sel,
  output logic       frame_end
);

  localparam int CMAX = (PRE_CYCLES > SEL_CYCLES) ? PRE_CYCLES : SEL_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(PRE_CYCLES - 1);
  localparam logic [CW-1:0] SEL_LAST = CW'(SEL_CYCLES - 1);

  logic [CW-1:0] cyc_q;

  assign accept    = (state_q == ST_IDLE) && start;
  assign cyc_end   = half_tick && sclk_q;
  assign enter_sel = (state_q == ST_CLOCKING) && cyc_end && (cyc_q == PRE_LAST);
  assign frame_end = (state_q == ST_SELECT) && cyc_end && (cyc_q == SEL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cyc_q <= '0;
          if (start) state_q <= ST_CLOCKING;
        end
        ST_CLOCKING: begin
          if (enter_sel) begin
            state_q <= ST_SELECT;
            cyc_q   <= '0;
          end else if (cyc_end) begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        ST_SELECT: begin
          if (frame_end) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
          end else if (cyc_end) begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cyc_q   <= '0;
        end
      endcase
    end
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_SELECT |=> state_q != ST_CLOCKING) else $error("restart from select"); // R7

  AST_CLOCKING_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CLOCKING && start) |=> state_q != ST_IDLE) else $error("start disturbed clocking"); // R7

endmodule

// File: rtl/ssg_out_regs.sv
module ssg_out_regs #(
  parameter int DATA_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic half_tick,
  input  logic cyc_end,
  input  logic enter_sel,
  input  logic frame_end,
  output logic sclk_q,
  output logic sdata_q,
  output logic cs_n_q,
  output logic busy_q
);

  localparam int DW = $clog2(DATA_CYCLES + 1);
  localparam logic [DW-1:0] DLAST = DW'(DATA_CYCLES - 1);

  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      dcnt_q  <= '0;
    end else if (accept) begin
      sclk_q  <= 1'b0;
      sdata_q <= 1'b1;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b1;
      dcnt_q  <= '0;
    end else if (frame_end) begin
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      if (half_tick) sclk_q <= ~sclk_q;
      if (enter_sel) cs_n_q <= 1'b0;
      if (cyc_end) begin
        if (dcnt_q == DLAST) begin
          dcnt_q  <= '0;
          sdata_q <= ~sdata_q;
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && sdata_q != $past(sdata_q)) |-> $fell(sclk_q))
    else $error("data changed off a falling serial edge"); // R5

endmodule

// File: rtl/serial_strobe_gen.sv
module serial_strobe_gen
  import ssg_pkg::*;
#(
  parameter int HALF_TICKS  = 20,
  parameter int PRE_CYCLES  = 8,
  parameter int SEL_CYCLES  = 4,
  parameter int DATA_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sclk,
  output logic sdata,
  output logic cs_n,
  output logic busy
);

  localparam int GW = $clog2(HALF_TICKS + 2) + 1;

  ssg_state_e state_q;
  logic       half_tick;
  logic       accept;
  logic       cyc_end;
  logic       enter_sel;
  logic       frame_end;
  logic       run;

  assign run = (state_q != ST_IDLE);

  ssg_tick_div #(
    .HALF_TICKS(HALF_TICKS)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .half_tick (half_tick)
  );

  ssg_ctrl #(
    .PRE_CYCLES(PRE_CYCLES),
    .SEL_CYCLES(SEL_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .half_tick (half_tick),
    .sclk_q    (sclk),
    .state_q   (state_q),
    .accept    (accept),
    .cyc_end   (cyc_end),
    .enter_sel (enter_sel),
    .frame_end (frame_end)
  );

  ssg_out_regs #(
    .DATA_CYCLES(DATA_CYCLES)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .half_tick (half_tick),
    .cyc_end   (cyc_end),
    .enter_sel (enter_sel),
    .frame_end (frame_end),
    .sclk_q    (sclk),
    .sdata_q   (sdata),
    .cs_n_q    (cs_n),
    .busy_q    (busy)
  );

  // Gap watch: cycles since the serial clock last changed while busy.
  logic [GW-1:0] gap_q;
  logic          sclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk;
      if (!busy || sclk != sclk_prev_q) gap_q <= '0;
      else                              gap_q <= gap_q + 1'b1;
    end
  end

  AST_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    gap_q <= GW'(HALF_TICKS)) else $error("serial clock stalled"); // R6

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && !sdata && cs_n)) else $error("idle levels wrong"); // R3

  AST_CS_WITHIN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy) else $error("chip select outside frame"); // R4

  AST_CS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $fell(sclk)) else $error("chip select off serial fall"); // R4

  AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!sclk && sdata && cs_n)) else $error("bad frame open"); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!busy && cs_n && !sclk && !sdata)) else $error("reset did not clear"); // R1

endmodule

// File: tb/serial_strobe_gen_tb_top.sv
module serial_strobe_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int H     = 20;
  localparam int PRE   = 8;
  localparam int SEL   = 4;
  localparam int DCYC  = 2;
  localparam int TOTAL = (PRE + SEL) * 2 * H;

  typedef struct {
    int   n;
    logic sclk;
    logic sdata;
    logic cs_n;
    logic busy;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sclk, sdata, cs_n, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_strobe_gen #(
    .HALF_TICKS (H),
    .PRE_CYCLES (PRE),
    .SEL_CYCLES (SEL),
    .DATA_CYCLES(DCYC)
  ) dut_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sclk  (sclk),
    .sdata (sdata),
    .cs_n  (cs_n),
    .busy  (busy)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input int n);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s edge %0d: actual %b expected %b", tag, n, act, exp);
    end
  endtask

  function automatic exp_t model(input int n);
    exp_t e;
    int k;
    e.n = n;
    if (n >= TOTAL) begin
      e.sclk = 1'b0; e.sdata = 1'b0; e.cs_n = 1'b1; e.busy = 1'b0;
    end else begin
      k       = n / (2 * H);
      e.sclk  = ((n / H) % 2) == 1;
      e.cs_n  = (k < PRE);
      e.sdata = ((k / DCYC) % 2) == 0;
      e.busy  = 1'b1;
    end
    return e;
  endfunction

  // Driver: issues one start, queues expected values for every edge of the frame,
  // and optionally pulses start again at edge offset ign (R7).
  task automatic frame(input int ign);
    @(negedge clk);
    start = 1'b1;
    for (int n = 0; n <= TOTAL; n++) q.push_back(model(n));
    for (int c = 1; c <= TOTAL; c++) begin
      @(negedge clk);
      start = (c == ign);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: compares each output one step after the edge it belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk("R2 sclk", sclk, e.sclk, e.n);
        chk("R4 cs_n", cs_n, e.cs_n, e.n);
        chk("R5 sdata", sdata, e.sdata, e.n);
        if (e.n == 0)          chk("R9 busy", busy, e.busy, e.n);
        else if (e.n == TOTAL) chk("R6 busy", busy, e.busy, e.n);
        else                   chk("R7 busy", busy, e.busy, e.n);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sclk", sclk, 1'b0, -1);
    chk("R1 sdata", sdata, 1'b0, -1);
    chk("R1 cs_n", cs_n, 1'b1, -1);
    chk("R1 busy", busy, 1'b0, -1);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R3: idle with no start
    chk("R3 sclk", sclk, 1'b0, -1);
    chk("R3 cs_n", cs_n, 1'b1, -1);
    chk("R3 busy", busy, 1'b0, -1);

    frame(0);          // plain frame
    frame(100);        // R7 start during clocking phase
    frame(2 * H * PRE + 7); // R7 start during select phase
    frame(TOTAL);      // R7 start on the last busy edge
    repeat (3) @(negedge clk);
    chk("R3 busy after frames", busy, 1'b0, -1);

    // R8: reset in the middle of a frame
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (99) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 sclk", sclk, 1'b0, -1);
    chk("R8 sdata", sdata, 1'b0, -1);
    chk("R8 cs_n", cs_n, 1'b1, -1);
    chk("R8 busy", busy, 1'b0, -1);
    repeat (2) @(negedge clk);
    frame(0);          // R8: counters cleared, full first half period again

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule